// File: doc/BRIEF.md
# DDR3 Command Packet Builder

This block sits on the processor side of a serial memory link. It takes in one DDR3 address/command beat per valid strobe and turns it into a fixed nine-byte frame. The frame is spread over a three-lane command link, and each lane carries one byte per symbol cycle. A whole frame therefore takes three symbol cycles. The command fields are packed into a 40-bit payload. The payload is wrapped in a start character, a rolling sequence number and a 16-bit CRC. Line coding and serialization happen further down the link. The bit clock is recovered from the data there, so no DDR3 clock pin is carried in the frame.

While a frame is going out, `busy` is high. If a command arrives during that time, it is parked in a one-entry holding register. The parked command is then sent directly after the current frame, with no idle gap. If a further command arrives while the holding register is already full, it is discarded.

Top module: `cmd_link_framer`

## Requirements
- R1: After reset, `busy`, `frameStart` and `frameEnd` are low and `laneData` is zero. The first frame sent carries sequence value 0.
- R2: The 40-bit payload holds, from its most significant bit down: address (16), bank (3), row/column strobes (2), write enable (1), rank (2), data mask (9), clock enable (2), then five zero bits.
- R3: Frame byte 0 is the start character 0xBC.
- R4: Frame byte 1 is an 8-bit sequence number. It rises by one for each frame sent and wraps from 255 to 0.
- R5: Frame bytes 7 (high) and 8 (low) hold a CRC-16 computed over bytes 1 to 6, most significant bit first. The generator polynomial is 0x1021 and the start value is 0xFFFF, with no reflection and no final inversion.
- R6: Frame bytes 2 to 6 carry the payload, most significant byte first. Frame byte k is driven on lane k mod 3 during symbol k/3. Lane j occupies `laneData[8j+7:8j]`.
- R7: A command sampled while the block is idle starts its frame on the next cycle. `busy` is then high for exactly three cycles. `frameStart` marks the first symbol and `frameEnd` marks the third.
- R8: A command sampled while a frame is in flight and the holding register is empty is sent directly after that frame. `busy` stays high across both frames.
- R9: A command sampled while a frame is in flight and the holding register is full is discarded. It produces no frame and uses up no sequence number.
- R10: While `busy` is low, `laneData` is zero and both frame markers are low.
- R11: Suppose a frame's last symbol cycle coincides with a new command while a command is parked. The parked command is sent next, and the new command takes its place in the holding register, so arrival order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A command beat is present this cycle |
| cmdAddr | input | 16 | DDR3 address field |
| cmdBank | input | 3 | Bank select |
| cmdStrobe | input | 2 | Row and column strobes |
| cmdWrEn | input | 1 | Write enable |
| cmdRank | input | 2 | Rank select |
| cmdMask | input | 9 | Data mask |
| cmdClkEn | input | 2 | Clock enable |
| laneData | output | 24 | One byte per lane, lane 0 in the low byte |
| frameStart | output | 1 | First symbol of a frame |
| frameEnd | output | 1 | Last symbol of a frame |
| busy | output | 1 | A frame symbol is on the lanes |

## Verification
The assertions assume that `cmdValid` is a plain one-cycle-per-command strobe and that reset is held low from time zero. With those assumptions, every frame begins from the idle or frame-end state, so the three-cycle framing and sequence-step properties hold for any command pattern. The stimulus changes inputs only just after a rising edge and drives each command for exactly one cycle. It deliberately hits the idle, in-flight-with-room, in-flight-full and last-symbol arrival cases, as well as a long run that wraps the sequence counter.

// File: rtl/cmd_link_pkg.sv
package cmd_link_pkg;

  localparam int ADDR_W  = 16;
  localparam int BANK_W  = 3;
  localparam int STRB_W  = 2;
  localparam int WE_W    = 1;
  localparam int RANK_W  = 2;
  localparam int MASK_W  = 9;
  localparam int CKE_W   = 2;

  localparam int FIELD_W       = ADDR_W + BANK_W + STRB_W + WE_W + RANK_W + MASK_W + CKE_W;
  localparam int PAYLOAD_BYTES = (FIELD_W + 7) / 8;
  localparam int PAYLOAD_W     = PAYLOAD_BYTES * 8;
  localparam int PAD_W         = PAYLOAD_W - FIELD_W;
  localparam int SEQ_W         = 8;
  localparam int CRC_W         = 16;
  localparam int BODY_BYTES    = 1 + PAYLOAD_BYTES;
  localparam int FRAME_BYTES   = 1 + BODY_BYTES + CRC_W / 8;
  localparam int FRAME_W       = FRAME_BYTES * 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] bank;
    logic [STRB_W-1:0] strobe;
    logic [WE_W-1:0]   wrEn;
    logic [RANK_W-1:0] rank;
    logic [MASK_W-1:0] mask;
    logic [CKE_W-1:0]  clkEn;
  } cmdFields_t;

  typedef struct packed {
    logic loadSkid;
    logic loadIn;
    logic parkIn;
  } ctrlStrobes_t;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] cur,
                                               input logic [7:0] dataByte);
    logic [CRC_W-1:0] acc;
    acc = cur;
    for (int i = 7; i >= 0; i--) begin
      if (acc[CRC_W-1] ^ dataByte[i]) acc = {acc[CRC_W-2:0], 1'b0} ^ CRC_POLY;
      else                            acc = {acc[CRC_W-2:0], 1'b0};
    end
    return acc;
  endfunction

endpackage

// File: rtl/cmd_link_ctrl.sv
module cmd_link_ctrl
  import cmd_link_pkg::*;
#(
  parameter int SYMS = 3
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cmdValid,
  output ctrlStrobes_t              strobes,
  output logic                      active,
  output logic [$clog2(SYMS)-1:0]   symIdx,
  output logic                      frameStart,
  output logic                      frameEnd
);

  localparam int SYM_W = $clog2(SYMS);
  localparam logic [SYM_W-1:0] LAST_SYM = SYM_W'(SYMS - 1);

  logic skidFull;
  logic atLast;
  logic canLoad;
  logic doLoad;

  assign atLast  = active && (symIdx == LAST_SYM);
  assign canLoad = !active || atLast;

  always_comb begin
    strobes.loadSkid = canLoad && skidFull;
    strobes.loadIn   = canLoad && !skidFull && cmdValid;
    // a new beat goes to the holding register when it cannot start now
    // and the register is empty or is being emptied this cycle
    strobes.parkIn   = cmdValid && !strobes.loadIn && (!skidFull || strobes.loadSkid);
  end

  assign doLoad = strobes.loadSkid || strobes.loadIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      symIdx   <= '0;
      skidFull <= 1'b0;
    end else begin
      if (strobes.parkIn)        skidFull <= 1'b1;
      else if (strobes.loadSkid) skidFull <= 1'b0;

      if (doLoad) begin
        active <= 1'b1;
        symIdx <= '0;
      end else if (atLast) begin
        active <= 1'b0;
        symIdx <= '0;
      end else if (active) begin
        symIdx <= symIdx + 1'b1;
      end
    end
  end

  assign frameStart = active && (symIdx == '0);
  assign frameEnd   = atLast;

endmodule

// File: rtl/cmd_link_dp.sv
module cmd_link_dp
  import cmd_link_pkg::*;
#(
  parameter int         LANES      = 3,
  parameter logic [7:0] START_CHAR = 8'hBC,
  parameter logic [15:0] CRC_SEED  = 16'hFFFF
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  cmdFields_t                             cmdIn,
  input  ctrlStrobes_t                           strobes,
  input  logic                                   active,
  input  logic [$clog2(FRAME_BYTES/LANES)-1:0]   symIdx,
  output logic [LANES*8-1:0]                     laneData
);

  localparam int SYMS  = FRAME_BYTES / LANES;
  localparam int SYM_W = $clog2(SYMS);
  localparam int IDX_W = $clog2(FRAME_BYTES);

  cmdFields_t          skidReg;
  logic [SEQ_W-1:0]    seqReg;
  logic [FRAME_W-1:0]  frameReg;

  cmdFields_t                srcCmd;
  logic [PAYLOAD_W-1:0]      payload;
  logic [BODY_BYTES*8-1:0]   body;
  logic [CRC_W-1:0]          crcChain [BODY_BYTES+1];
  logic [FRAME_W-1:0]        newFrame;
  logic [7:0]                frameBytes [FRAME_BYTES];

  assign srcCmd  = strobes.loadSkid ? skidReg : cmdIn;
  assign payload = {srcCmd, {PAD_W{1'b0}}};
  assign body    = {seqReg, payload};

  assign crcChain[0] = CRC_SEED;
  for (genvar i = 0; i < BODY_BYTES; i++) begin : g_crc
    assign crcChain[i+1] = crcByte(crcChain[i], body[(BODY_BYTES-1-i)*8 +: 8]);
  end

  assign newFrame = {START_CHAR, body, crcChain[BODY_BYTES]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      skidReg  <= '0;
      seqReg   <= '0;
      frameReg <= '0;
    end else begin
      if (strobes.parkIn) skidReg <= cmdIn;
      if (strobes.loadSkid || strobes.loadIn) begin
        frameReg <= newFrame;
        seqReg   <= seqReg + 1'b1;
      end
    end
  end

  for (genvar b = 0; b < FRAME_BYTES; b++) begin : g_bytes
    assign frameBytes[b] = frameReg[(FRAME_BYTES-1-b)*8 +: 8];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IDX_W-1:0] byteIdx;
    assign byteIdx = IDX_W'(symIdx) * IDX_W'(LANES) + IDX_W'(l);
    assign laneData[l*8 +: 8] = active ? frameBytes[byteIdx] : 8'h00;
  end

endmodule

// File: rtl/cmd_link_framer.sv
module cmd_link_framer
  import cmd_link_pkg::*;
#(
  parameter int          LANES      = 3,
  parameter logic [7:0]  START_CHAR = 8'hBC,
  parameter logic [15:0] CRC_SEED   = 16'hFFFF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [ADDR_W-1:0]    cmdAddr,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic [STRB_W-1:0]    cmdStrobe,
  input  logic [WE_W-1:0]      cmdWrEn,
  input  logic [RANK_W-1:0]    cmdRank,
  input  logic [MASK_W-1:0]    cmdMask,
  input  logic [CKE_W-1:0]     cmdClkEn,
  output logic [LANES*8-1:0]   laneData,
  output logic                 frameStart,
  output logic                 frameEnd,
  output logic                 busy
);

  localparam int SYMS  = FRAME_BYTES / LANES;
  localparam int SYM_W = $clog2(SYMS);

  cmdFields_t         cmdIn;
  ctrlStrobes_t       strobes;
  logic               active;
  logic [SYM_W-1:0]   symIdx;

  assign cmdIn = {cmdAddr, cmdBank, cmdStrobe, cmdWrEn, cmdRank, cmdMask, cmdClkEn};

  cmd_link_ctrl #(.SYMS(SYMS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .strobes    (strobes),
    .active     (active),
    .symIdx     (symIdx),
    .frameStart (frameStart),
    .frameEnd   (frameEnd)
  );

  cmd_link_dp #(
    .LANES      (LANES),
    .START_CHAR (START_CHAR),
    .CRC_SEED   (CRC_SEED)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmdIn    (cmdIn),
    .strobes  (strobes),
    .active   (active),
    .symIdx   (symIdx),
    .laneData (laneData)
  );

  assign busy = active;

endmodule

// File: rtl/cmd_link_framer_chk.sv
module cmd_link_framer_chk #(
  parameter int         LANES      = 3,
  parameter logic [7:0] START_CHAR = 8'hBC
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic [LANES*8-1:0] laneData,
  input logic               frameStart,
  input logic               frameEnd,
  input logic               busy
);

  logic [7:0] lastSeq;
  logic       seenFrame;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastSeq   <= 8'd0;
      seenFrame <= 1'b0;
    end else if (frameStart) begin
      lastSeq   <= laneData[15:8];
      seenFrame <= 1'b1;
    end
  end

  assert_first_seq_R1: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !seenFrame) |-> (laneData[15:8] == 8'd0));

  assert_start_char_R3: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (laneData[7:0] == START_CHAR));

  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && seenFrame) |-> (laneData[15:8] == 8'(lastSeq + 8'd1)));

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> busy);

  assert_mid_symbol_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (busy && !frameStart && !frameEnd));

  assert_end_third_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> ##1 frameEnd);

  assert_idle_accept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && cmdValid) |=> frameStart);

  assert_after_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (frameStart || !busy));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (laneData == '0 && !frameStart && !frameEnd));

endmodule

bind cmd_link_framer cmd_link_framer_chk #(
  .LANES      (LANES),
  .START_CHAR (START_CHAR)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cmdValid   (cmdValid),
  .laneData   (laneData),
  .frameStart (frameStart),
  .frameEnd   (frameEnd),
  .busy       (busy)
);

// File: tb/cmd_link_framer_bench.sv
module cmd_link_framer_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [15:0] cmdAddr = '0;
  logic [2:0]  cmdBank = '0;
  logic [1:0]  cmdStrobe = '0;
  logic [0:0]  cmdWrEn = '0;
  logic [1:0]  cmdRank = '0;
  logic [8:0]  cmdMask = '0;
  logic [1:0]  cmdClkEn = '0;
  logic [23:0] laneData;
  logic        frameStart;
  logic        frameEnd;
  logic        busy;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 0;
  logic [7:0]  benchSeq = 8'd0;
  logic [71:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_link_framer u_cmd_link_framer (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid),
    .cmdAddr(cmdAddr), .cmdBank(cmdBank), .cmdStrobe(cmdStrobe), .cmdWrEn(cmdWrEn),
    .cmdRank(cmdRank), .cmdMask(cmdMask), .cmdClkEn(cmdClkEn),
    .laneData(laneData), .frameStart(frameStart), .frameEnd(frameEnd), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [71:0] act,
                       input logic [71:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // CRC-16, polynomial 0x1021, start 0xFFFF, bit-serial over 48 bits
  function automatic logic [15:0] benchCrc(input logic [47:0] bits);
    logic [15:0] c = 16'hFFFF;
    for (int i = 47; i >= 0; i--) begin
      logic fb;
      fb = c[15] ^ bits[i];
      c = c << 1;
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [71:0] benchFrame(input logic [34:0] f, input logic [7:0] s);
    logic [39:0] pay;
    pay = {f, 5'b00000};
    return {8'hBC, s, pay, benchCrc({s, pay})};
  endfunction

  task automatic sendCmd(input logic [34:0] f, input bit kept);
    {cmdAddr, cmdBank, cmdStrobe, cmdWrEn, cmdRank, cmdMask, cmdClkEn} = f;
    cmdValid = 1'b1;
    if (kept) begin
      expQ.push_back(benchFrame(f, benchSeq));
      benchSeq = benchSeq + 8'd1;
    end
    @(posedge clk);
    #1;
    cmdValid = 1'b0;
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: gathers lane bytes of each frame and compares with the queue
  int          monSym = 0;
  logic [71:0] got = '0;

  always @(negedge clk) begin
    if (rstN) begin
      if (busy) begin
        check(frameStart == (monSym == 0), "R7 frameStart position", 72'(frameStart), 72'(monSym == 0));
        check(frameEnd == (monSym == 2), "R7 frameEnd position", 72'(frameEnd), 72'(monSym == 2));
        for (int l = 0; l < 3; l++) begin
          int k;
          k = monSym * 3 + l;
          got[(8 - k) * 8 +: 8] = laneData[l * 8 +: 8];
        end
        if (monSym == 2) begin
          monSym = 0;
          if (expQ.size() == 0) begin
            check(1'b0, "R9 unexpected frame", got, 72'd0);
          end else begin
            logic [71:0] exp;
            exp = expQ.pop_front();
            check(got[71:64] == exp[71:64], "R3 start char", 72'(got[71:64]), 72'(exp[71:64]));
            check(got[63:56] == exp[63:56], "R4 sequence", 72'(got[63:56]), 72'(exp[63:56]));
            check(got[55:16] == exp[55:16], "R2 payload packing", 72'(got[55:16]), 72'(exp[55:16]));
            check(got[15:0] == exp[15:0], "R5 crc", 72'(got[15:0]), 72'(exp[15:0]));
            check(got == exp, "R6 lane striping", got, exp);
          end
        end else begin
          monSym = monSym + 1;
        end
      end else begin
        check(monSym == 0, "R7 frame cut short", 72'(monSym), 72'd0);
        monSym = 0;
        check(laneData == 24'd0 && !frameStart && !frameEnd, "R10 idle outputs",
              72'({laneData, frameStart, frameEnd}), 72'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !frameStart && !frameEnd && laneData == 24'd0, "R1 reset outputs",
          72'({laneData, busy, frameStart, frameEnd}), 72'd0);
    @(posedge clk);
    #1;
    rstN = 1'b1;
    idleCycles(2);

    // R1 R2 R7: single command from idle, first seq 0, exact busy window
    sendCmd(35'h7_FFFF_FFFF, 1'b1);
    @(negedge clk);
    check(frameStart && busy, "R7 start next cycle", 72'({frameStart, busy}), 72'b11);
    check(laneData[15:8] == 8'd0, "R1 first sequence zero", 72'(laneData[15:8]), 72'd0);
    @(negedge clk);
    check(busy, "R7 busy symbol 2", 72'(busy), 72'd1);
    @(negedge clk);
    check(busy && frameEnd, "R7 busy symbol 3", 72'({busy, frameEnd}), 72'b11);
    @(negedge clk);
    check(!busy, "R7 busy drops after three", 72'(busy), 72'd0);
    @(posedge clk);
    #1;

    // R2: distinct field patterns
    sendCmd({16'h8001, 3'b101, 2'b10, 1'b1, 2'b01, 9'h155, 2'b10}, 1'b1);
    idleCycles(4);
    sendCmd(35'd0, 1'b1);
    idleCycles(4);
    sendCmd({16'h1234, 3'b010, 2'b01, 1'b0, 2'b10, 9'h0AA, 2'b01}, 1'b1);
    idleCycles(4);

    // R8: second command during a frame is sent back to back
    sendCmd(35'h1_2345_6789, 1'b1);
    sendCmd(35'h6_5432_1ABC, 1'b1);
    repeat (5) begin
      @(negedge clk);
      check(busy, "R8 busy held across both frames", 72'(busy), 72'd1);
    end
    idleCycles(3);

    // R9: third command with holding register full is dropped
    sendCmd(35'h0_1111_2222, 1'b1);
    sendCmd(35'h0_3333_4444, 1'b1);
    sendCmd(35'h0_5555_6666, 1'b0);
    idleCycles(8);
    sendCmd(35'h0_7777_0001, 1'b1);
    idleCycles(4);

    // R11: new command on the last symbol while one is parked
    sendCmd(35'h2_AAAA_0001, 1'b1);
    sendCmd(35'h2_AAAA_0002, 1'b1);
    idleCycles(1);
    sendCmd(35'h2_AAAA_0003, 1'b1);
    idleCycles(10);

    // R4: long stream wrapping the sequence counter
    for (int n = 0; n < 260; n++) begin
      sendCmd(35'($urandom()) ^ {n[2:0], 32'd0}, 1'b1);
      idleCycles(2);
    end
    idleCycles(10);

    check(expQ.size() == 0, "R9 all expected frames seen", 72'(expQ.size()), 72'd0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule